// File: doc/BRIEF.md
# Triggered Frequency Ramp Generator

This block drives the tuning word and phase accumulator of a direct digital synthesizer so that it produces either a linear frequency sweep (chirp) or a coarse stepped-frequency sequence. A rising edge on the trigger input clears the phase accumulator and loads the start tuning word. The tuning word then grows by a programmed step after every programmed number of clocks until it reaches the upper limit. Every pulse therefore begins at the same frequency and the same phase.

When the limit is reached, a one-cycle ramp-over flag is raised in step with the final tuning word. Capture logic can use it as a trigger that is exact to the sample. In no-dwell mode the generator then returns to idle, with a zero tuning word and a zero phase. In hold mode it stays at the limit frequency until the next trigger. A stepped sequence uses the same datapath with a long step interval. The phase-to-amplitude conversion and the converter that follows lie outside this block.

Top module: `chirp_ramp_gen`

## Requirements
- R1: A ramp starts when `trig_i` is sampled 1 at a rising clock edge after being sampled 0 at the edge before, while the generator is idle or holding. Keeping `trig_i` high longer starts nothing more.
- R2: In the first cycle after the start edge, `phase_o` is 0, `active_o` is 1 and `ftw_o` equals `start_word_i`.
- R3: Each tuning word is held for `interval_i` clock cycles and then grows by `step_word_i`. An `interval_i` of 0 behaves as 1.
- R4: While the generator is active, `phase_o` grows by the current `ftw_o` on every clock, modulo 2^32.
- R5: When the next step would reach or pass `limit_word_i` (a carry out of bit 31 included), `ftw_o` is set to `limit_word_i` and `ramp_over_o` is 1 for exactly that one cycle. A start word at or above the limit gives this on the first cycle.
- R6: With `hold_i` = 0, in the cycle after `ramp_over_o`, `ftw_o` and `phase_o` are 0 and `active_o` is 0. They stay that way until the next start.
- R7: With `hold_i` = 1, after `ramp_over_o` the generator keeps `ftw_o` at the limit, keeps accumulating phase and keeps `active_o` at 1. A new trigger edge restarts the ramp from R2.
- R8: A trigger edge that arrives while a ramp is stepping, or in its ramp-over cycle, has no effect on `ftw_o` or `phase_o`.
- R9: While reset is asserted, and after it, `ftw_o`, `phase_o`, `ramp_over_o` and `active_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Start trigger; its rising edge is used |
| hold_i | input | 1 | 1: hold the limit frequency after the ramp; 0: no dwell |
| start_word_i | input | 32 | Tuning word loaded at the start |
| limit_word_i | input | 32 | Upper limit of the tuning word |
| step_word_i | input | 32 | Increment added at each step |
| interval_i | input | 24 | Clock cycles per step |
| ftw_o | output | 32 | Current tuning word |
| phase_o | output | 32 | Phase accumulator |
| ramp_over_o | output | 1 | One-cycle flag in the cycle the limit is reached |
| active_o | output | 1 | Ramp running, finishing or holding |

## Verification
The hardest situation to reach is a trigger edge that lands in the middle of a running ramp, or while the generator is holding after a ramp. Both need exact cycle placement relative to an earlier trigger. The driver raises a second one-cycle trigger pulse a fixed number of cycles after the first, with the step interval set to one so that the pulse is sure to fall inside the stepping phase. A later ramp is started straight from the hold state. The clamp is driven both by an exact hit on the limit and by a step that carries out of 32 bits, and a trigger held high for several cycles checks that only its edge counts.

// File: rtl/chirp_pkg.sv
package chirp_pkg;
  localparam int unsigned FTW_W = 32;
  localparam int unsigned IVL_W = 24;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RAMP = 2'd1,
    ST_END  = 2'd2,
    ST_HOLD = 2'd3
  } ramp_state_e;
endpackage

// File: rtl/chirp_trig_edge.sv
module chirp_trig_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rise_o
);
  logic trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b1;  // a trigger held high through reset is not an edge
    else         trig_q <= trig_i;
  end

  assign rise_o = trig_i & ~trig_q;

  assert_single_edge_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/chirp_step_timer.sv
module chirp_step_timer #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] interval_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last   = (interval_i == '0) ? '0 : interval_i - 1'b1;
  assign tick_o = run_i & (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i || tick_o) cnt_q <= '0;
    else if (run_i)             cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> cnt_q == '0);
endmodule

// File: rtl/chirp_ftw_ramp.sv
module chirp_ftw_ramp #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         adv_i,
  input  logic         zero_i,
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] limit_i,
  input  logic [W-1:0] step_i,
  output logic         term_o,
  output logic [W-1:0] ftw_o
);
  logic [W-1:0] ftw_q;
  logic [W:0]   sum_w;
  logic         start_hit, step_hit;

  assign sum_w     = {1'b0, ftw_q} + {1'b0, step_i};  // carry kept for the clamp
  assign start_hit = start_i >= limit_i;
  assign step_hit  = sum_w >= {1'b0, limit_i};
  assign term_o    = (load_i & start_hit) | (adv_i & step_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ftw_q <= '0;
    else if (zero_i) ftw_q <= '0;
    else if (load_i) ftw_q <= start_hit ? limit_i : start_i;
    else if (adv_i)  ftw_q <= step_hit ? limit_i : sum_w[W-1:0];
  end

  assign ftw_o = ftw_q;

  assert_monotonic_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && !zero_i) |=> ftw_q >= $past(ftw_q));
endmodule

// File: rtl/chirp_phase_acc.sv
module chirp_phase_acc #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] ftw_i,
  output logic [W-1:0] phase_o
);
  logic [W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    phase_q <= '0;
    else if (clr_i) phase_q <= '0;
    else if (en_i)  phase_q <= phase_q + ftw_i;
  end

  assign phase_o = phase_q;

  assert_clear_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> phase_q == '0);
endmodule

// File: rtl/chirp_ramp_gen.sv
module chirp_ramp_gen
  import chirp_pkg::*;
#(
  parameter int unsigned W     = FTW_W,
  parameter int unsigned CNT_W = IVL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             hold_i,
  input  logic [W-1:0]     start_word_i,
  input  logic [W-1:0]     limit_word_i,
  input  logic [W-1:0]     step_word_i,
  input  logic [CNT_W-1:0] interval_i,
  output logic [W-1:0]     ftw_o,
  output logic [W-1:0]     phase_o,
  output logic             ramp_over_o,
  output logic             active_o
);
  ramp_state_e state_q, state_d;
  logic trig_rise, start_ramp, term, tick, adv, finish_idle;

  chirp_trig_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .rise_o (trig_rise)
  );

  // a trigger is accepted only outside a running ramp
  assign start_ramp  = trig_rise & ((state_q == ST_IDLE) | (state_q == ST_HOLD));
  assign adv         = tick & (state_q == ST_RAMP);
  assign finish_idle = (state_q == ST_END) & ~hold_i;

  chirp_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (start_ramp),
    .run_i      (state_q == ST_RAMP),
    .interval_i (interval_i),
    .tick_o     (tick)
  );

  chirp_ftw_ramp #(.W(W)) u_ftw (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_ramp),
    .adv_i   (adv),
    .zero_i  (finish_idle),
    .start_i (start_word_i),
    .limit_i (limit_word_i),
    .step_i  (step_word_i),
    .term_o  (term),
    .ftw_o   (ftw_o)
  );

  chirp_phase_acc #(.W(W)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_ramp | finish_idle),
    .en_i    (state_q != ST_IDLE),
    .ftw_i   (ftw_o),
    .phase_o (phase_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_HOLD: if (start_ramp) state_d = term ? ST_END : ST_RAMP;
      ST_RAMP:          if (term)       state_d = ST_END;
      ST_END:           state_d = hold_i ? ST_HOLD : ST_IDLE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign ramp_over_o = (state_q == ST_END);
  assign active_o    = (state_q != ST_IDLE);

  assert_over_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_over_o |=> !ramp_over_o);
  assert_over_at_limit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_over_o |-> ftw_o == limit_word_i);
  assert_no_dwell_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_over_o && !hold_i) |=> (ftw_o == '0 && phase_o == '0 && !active_o));
  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ramp |=> (phase_o == '0 && active_o));
  assert_phase_acc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !start_ramp && !finish_idle) |=> phase_o == $past(phase_o + ftw_o));
  assert_busy_ignore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RAMP && trig_rise && !term) |=> state_q == ST_RAMP);
endmodule

// File: tb/chirp_ramp_gen_tb_top.sv
module chirp_ramp_gen_tb_top;
  typedef struct {
    logic [31:0] ftw;
    logic [31:0] phase;
    logic        over;
    logic        act;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic        hold = 1'b0;
  logic [31:0] start_w = '0, limit_w = '0, step_w = '0;
  logic [23:0] ivl = '0;
  logic [31:0] ftw, phase;
  logic        over, act;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  chirp_ramp_gen dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .trig_i       (trig),
    .hold_i       (hold),
    .start_word_i (start_w),
    .limit_word_i (limit_w),
    .step_word_i  (step_w),
    .interval_i   (ivl),
    .ftw_o        (ftw),
    .phase_o      (phase),
    .ramp_over_o  (over),
    .active_o     (act)
  );

  always #5 clk = ~clk;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  task automatic push(input logic [31:0] f, input logic [31:0] p,
                      input logic o, input logic a, input string t);
    exp_t e;
    e.ftw = f; e.phase = p; e.over = o; e.act = a; e.tag = t;
    exp_q.push_back(e);
  endtask

  // expected per-cycle trace, starting with the cycle after the start edge
  task automatic build(input int n_hold);
    logic [31:0] f, ph;
    logic [32:0] nxt;
    int n;
    n  = (ivl == 0) ? 1 : int'(ivl);
    ph = '0;
    if (start_w >= limit_w) begin
      push(limit_w, ph, 1'b1, 1'b1, "R5");
      ph += limit_w;
    end else begin
      f = start_w;
      for (int lvl = 0; lvl < 1000; lvl++) begin
        for (int k = 0; k < n; k++) begin
          push(f, ph, 1'b0, 1'b1, (lvl == 0 && k == 0) ? "R2" : "R3");
          ph += f;
        end
        nxt = {1'b0, f} + {1'b0, step_w};
        if (nxt >= {1'b0, limit_w}) break;
        f = nxt[31:0];
      end
      push(limit_w, ph, 1'b1, 1'b1, "R5");
      ph += limit_w;
    end
    if (hold) begin
      for (int h = 0; h < n_hold; h++) begin
        push(limit_w, ph, 1'b0, 1'b1, "R7");
        ph += limit_w;
      end
    end else begin
      for (int h = 0; h < 4; h++) push('0, '0, 1'b0, 1'b0, "R6");
    end
  endtask

  task automatic run_ramp(input logic [31:0] s, input logic [31:0] l,
                          input logic [31:0] st, input logic [23:0] iv,
                          input logic hm, input int trig_len, input int glitch_at);
    @(negedge clk);
    start_w = s; limit_w = l; step_w = st; ivl = iv; hold = hm;
    trig = 1'b1;
    @(posedge clk);
    build(5);
    for (int i = 1; i < trig_len; i++) @(negedge clk);
    @(negedge clk);
    trig = 1'b0;
    if (glitch_at > 0) begin
      // R8: second edge while the ramp is stepping
      repeat (glitch_at) @(negedge clk);
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
    end
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (ftw !== e.ftw || phase !== e.phase || over !== e.over || act !== e.act) begin
          n_fail++;
          $display("FAIL %s: actual ftw=%h ph=%h over=%b act=%b expected ftw=%h ph=%h over=%b act=%b",
                   e.tag, ftw, phase, over, act, e.ftw, e.phase, e.over, e.act);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (ftw !== 0 || phase !== 0 || over !== 0 || act !== 0) begin
      n_fail++;
      $display("FAIL R9: actual ftw=%h ph=%h over=%b act=%b expected all zero", ftw, phase, over, act);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    n_chk++;
    if (ftw !== 0 || phase !== 0 || over !== 0 || act !== 0) begin
      n_fail++;
      $display("FAIL R9: actual ftw=%h ph=%h over=%b act=%b expected all zero after reset",
               ftw, phase, over, act);
    end
    // R3 R5 exact hit on the limit, no dwell
    run_ramp(32'd0, 32'd100, 32'd10, 24'd3, 1'b0, 1, 0);
    // R5 overshoot clamped to the limit
    run_ramp(32'd5, 32'd40, 32'd12, 24'd2, 1'b0, 1, 0);
    // R3 interval 0 acts as 1, R7 hold, R8 edge during the ramp ignored
    run_ramp(32'h100, 32'h800, 32'h100, 24'd0, 1'b1, 1, 2);
    // R7 restart from hold; R5 start at limit; R1 long high trigger
    run_ramp(32'd1000, 32'd1000, 32'd1, 24'd4, 1'b0, 5, 0);
    // R3 stepped sequence with long dwell per level
    run_ramp(32'd200, 32'd1800, 32'd200, 24'd40, 1'b0, 1, 0);
    // R4 R5 phase wrap and carry out of bit 31
    run_ramp(32'hC000_0000, 32'hFFFF_FFFF, 32'h2000_0000, 24'd2, 1'b0, 1, 0);
    // R1 trigger still low: nothing starts
    repeat (5) @(negedge clk);
    n_chk++;
    if (act !== 0 || ftw !== 0) begin
      n_fail++;
      $display("FAIL R1: actual act=%b ftw=%h expected idle", act, ftw);
    end
    finish_run();
  end
endmodule